// File: doc/BRIEF.md
# Clock Recovery Lock-Mode Controller

This controller chooses whether a clock recovery loop follows its local reference clock or the incoming serial data. It compares the frequency of a divided loop clock with the reference clock. It does this by counting loop-clock edges over a fixed window of reference cycles. The count is carried across the clock boundary in Gray code.

Two external flags come from analog circuits: signal present and phase aligned. When both are true together with a frequency match inside the selected ppm tolerance, the controller moves the loop to data tracking. It drops back to reference tracking as soon as the signal is lost or a window measures out of tolerance. Two manual inputs can pin the mode either way.

The status output only reports which mode is active. It says nothing about whether the loop has acquired phase on the data.

Top module: `cru_lock_ctrl`

## Requirements
- R1: During and right after reset, the controller tracks the reference: `lock_to_data` and `freq_locked` are 0.
- R2: `freq_locked` equals `lock_to_data` in every cycle. Once in data mode, a low `phase_ok` alone does not take the controller out of data mode.
- R3: `tol_sel` picks the tolerance. The codes 0 to 7 mean 62.5, 100, 125, 200, 250, 300, 500 and 1000 ppm. The allowed count error is ceil(ppm × 2^WIN_LOG2 / 10^6).
- R4: A measurement window lasts 2^WIN_LOG2 reference cycles. A window passes when the count of loop-clock rising edges in it differs from 2^WIN_LOG2 by no more than the allowed count error.
- R5: In automatic mode (both manual inputs low), data mode is entered only when three things are true in the same cycle: the frequency is qualified, `sig_present` is 1 and `phase_ok` is 1.
- R6: After reset or a restart, the first window boundary only records a baseline. The frequency becomes qualified after two consecutive passing windows that follow it.
- R7: In automatic mode, a low `sig_present` while in data mode returns the controller to reference mode on the next reference edge. Frequency qualification is kept, so the controller re-enters data mode once the signal returns, provided the phase is aligned.
- R8: In automatic mode, a window that fails the tolerance check returns the controller to reference mode on the next edge and clears qualification.
- R9: `force_ref` high puts the controller in reference mode on the next edge, whatever `force_data` is.
- R10: `force_data` high with `force_ref` low puts the controller in data mode on the next edge, regardless of the signal, phase and frequency conditions.
- R11: A change of `tol_sel` discards qualification and restarts measurement with a new baseline window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| loop_clk | input | 1 | Divided clock from the recovery loop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sig_present | input | 1 | Serial input is above the signal-loss threshold |
| phase_ok | input | 1 | Reference and loop phases are aligned |
| tol_sel | input | 3 | Frequency tolerance code (R3) |
| force_ref | input | 1 | Manual override to reference tracking |
| force_data | input | 1 | Manual override to data tracking |
| lock_to_data | output | 1 | 1 selects data tracking, 0 selects reference tracking |
| freq_locked | output | 1 | Mode flag: high while in data tracking |

## Verification
The bench builds the controller with WIN_LOG2 = 12. This gives a 4096-cycle window, so a full lock sequence fits in about three windows and many scenarios fit in one run. At this size the allowed error ranges from 1 count at 62.5 ppm to 5 counts at 1000 ppm. A loop clock about 800 ppm fast is therefore rejected by the tight settings and accepted by the loose one, which exercises the tolerance coding. A loop clock 2% fast exercises window failure while the controller is in data mode.

// File: rtl/cru_lock_pkg.sv
package cru_lock_pkg;

  typedef enum logic { MODE_REF = 1'b0, MODE_DATA = 1'b1 } lock_mode_e;

  // Tolerance in tenths of ppm for each select code.
  function automatic logic [63:0] tol_tenths_ppm(input logic [2:0] sel);
    case (sel)
      3'd0:    return 64'd625;
      3'd1:    return 64'd1000;
      3'd2:    return 64'd1250;
      3'd3:    return 64'd2000;
      3'd4:    return 64'd2500;
      3'd5:    return 64'd3000;
      3'd6:    return 64'd5000;
      default: return 64'd10000;
    endcase
  endfunction

  // Allowed count error over a 2^win_log2 window, rounded up.
  function automatic logic [31:0] tol_counts(input logic [2:0] sel, input int win_log2);
    logic [63:0] num;
    num = (tol_tenths_ppm(sel) << win_log2) + 64'd9_999_999;
    return 32'(num / 64'd10_000_000);
  endfunction

endpackage

// File: rtl/loop_edge_counter.sv
module loop_edge_counter #(
  parameter int CNT_W = 14
) (
  input  logic             loop_clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge loop_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/freq_window.sv
module freq_window #(
  parameter int WIN_LOG2 = 20,
  parameter int CNT_W    = WIN_LOG2 + 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] gray_in,
  input  logic [CNT_W-1:0] tol,
  output logic             win_done,
  output logic             win_pass
);
  localparam logic [CNT_W-1:0] NOM = CNT_W'(1) << WIN_LOG2;

  function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [WIN_LOG2-1:0] win_cnt;
  logic                primed;
  logic [CNT_W-1:0]    prev_bin;
  logic [CNT_W-1:0]    cur_bin;
  logic [CNT_W-1:0]    delta;
  logic [CNT_W-1:0]    offs;
  logic [CNT_W-1:0]    absd;
  logic                boundary;

  assign boundary = &win_cnt;
  assign cur_bin  = gray2bin(gray_in);
  assign delta    = cur_bin - prev_bin;
  assign offs     = delta - NOM;
  assign absd     = offs[CNT_W-1] ? (~offs + 1'b1) : offs;
  assign win_done = boundary && primed && !restart;
  assign win_pass = (absd <= tol);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      primed   <= 1'b0;
      prev_bin <= '0;
    end else if (restart) begin
      win_cnt  <= '0;
      primed   <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (boundary) begin
        prev_bin <= cur_bin;
        primed   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import cru_lock_pkg::*;
#(
  parameter int PASS_NEED = 2
) (
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       win_done,
  input  logic       win_pass,
  input  logic       sig_present,
  input  logic       phase_ok,
  input  logic       force_ref,
  input  logic       force_data,
  output lock_mode_e mode,
  output logic       qualified
);
  localparam int PW = $clog2(PASS_NEED + 1);

  logic [PW-1:0] pass_cnt;
  logic          win_fail;
  lock_mode_e    auto_nx;
  lock_mode_e    mode_nx;

  assign qualified = (pass_cnt == PW'(PASS_NEED));
  assign win_fail  = win_done && !win_pass;

  always_comb begin
    if (mode == MODE_REF)
      auto_nx = (qualified && sig_present && phase_ok && !win_fail) ? MODE_DATA : MODE_REF;
    else
      auto_nx = (!sig_present || win_fail) ? MODE_REF : MODE_DATA;
    if (force_ref)       mode_nx = MODE_REF;
    else if (force_data) mode_nx = MODE_DATA;
    else                 mode_nx = auto_nx;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_REF;
      pass_cnt <= '0;
    end else begin
      mode <= mode_nx;
      if (restart || win_fail)
        pass_cnt <= '0;
      else if (win_done && !qualified)
        pass_cnt <= pass_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cru_lock_ctrl.sv
module cru_lock_ctrl
  import cru_lock_pkg::*;
#(
  parameter int WIN_LOG2  = 20,
  parameter int PASS_NEED = 2
) (
  input  logic       ref_clk,
  input  logic       loop_clk,
  input  logic       rst_n,
  input  logic       sig_present,
  input  logic       phase_ok,
  input  logic [2:0] tol_sel,
  input  logic       force_ref,
  input  logic       force_data,
  output logic       lock_to_data,
  output logic       freq_locked
);
  localparam int CNT_W = WIN_LOG2 + 2;

  logic [CNT_W-1:0] gray_loop;
  logic [CNT_W-1:0] gray_ref;
  logic [CNT_W-1:0] tol_tab [8];
  logic [2:0]       tol_q;
  logic             tol_chg;
  logic             win_done;
  logic             win_pass;
  logic             qualified;
  lock_mode_e       mode;

  for (genvar g = 0; g < 8; g++) begin : g_tol
    assign tol_tab[g] = CNT_W'(tol_counts(3'(g), WIN_LOG2));
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) tol_q <= '0;
    else        tol_q <= tol_sel;
  end
  assign tol_chg = (tol_sel != tol_q);

  loop_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .loop_clk (loop_clk),
    .rst_n    (rst_n),
    .gray_o   (gray_loop)
  );

  gray_sync #(.W(CNT_W)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d     (gray_loop),
    .q     (gray_ref)
  );

  freq_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .restart  (tol_chg),
    .gray_in  (gray_ref),
    .tol      (tol_tab[tol_sel]),
    .win_done (win_done),
    .win_pass (win_pass)
  );

  lock_fsm #(.PASS_NEED(PASS_NEED)) u_fsm (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .restart     (tol_chg),
    .win_done    (win_done),
    .win_pass    (win_pass),
    .sig_present (sig_present),
    .phase_ok    (phase_ok),
    .force_ref   (force_ref),
    .force_data  (force_data),
    .mode        (mode),
    .qualified   (qualified)
  );

  assign lock_to_data = (mode == MODE_DATA);
  assign freq_locked  = (mode == MODE_DATA);
endmodule

// File: rtl/cru_lock_chk.sv
module cru_lock_chk (
  input logic ref_clk,
  input logic rst_n,
  input logic sig_present,
  input logic phase_ok,
  input logic force_ref,
  input logic force_data,
  input logic tol_chg,
  input logic win_done,
  input logic win_pass,
  input logic qualified,
  input logic lock_to_data,
  input logic freq_locked
);
  logic auto_m;
  assign auto_m = !force_ref && !force_data;

  always @(posedge ref_clk) begin
    if (!rst_n) assert_reset_ref_R1: assert (!lock_to_data && !freq_locked);
  end

  assert_flag_mode_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    freq_locked == lock_to_data);

  assert_phase_drop_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lock_to_data && auto_m && sig_present && !phase_ok && !(win_done && !win_pass))
    |=> lock_to_data);

  assert_entry_cond_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!lock_to_data && auto_m && !(sig_present && phase_ok && qualified)) |=> !lock_to_data);

  assert_sig_loss_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (lock_to_data && auto_m && !sig_present) |=> !lock_to_data);

  assert_win_fail_R8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (win_done && !win_pass && !force_data) |=> (!lock_to_data && !qualified));

  assert_force_ref_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    force_ref |=> !lock_to_data);

  assert_force_data_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (force_data && !force_ref) |=> lock_to_data);

  assert_tol_restart_R11: assert property (@(posedge ref_clk) disable iff (!rst_n)
    tol_chg |=> !qualified);
endmodule

bind cru_lock_ctrl cru_lock_chk u_chk (
  .ref_clk      (ref_clk),
  .rst_n        (rst_n),
  .sig_present  (sig_present),
  .phase_ok     (phase_ok),
  .force_ref    (force_ref),
  .force_data   (force_data),
  .tol_chg      (tol_chg),
  .win_done     (win_done),
  .win_pass     (win_pass),
  .qualified    (qualified),
  .lock_to_data (lock_to_data),
  .freq_locked  (freq_locked)
);

// File: tb/tb_cru_lock_ctrl.sv
`timescale 1ps/1ps
module tb_cru_lock_ctrl;
  localparam int WLOG = 12;
  localparam int WIN  = 1 << WLOG;
  localparam int REF_HALF = 2500;

  logic       ref_clk = 1'b0;
  logic       loop_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sig_present = 1'b0;
  logic       phase_ok = 1'b0;
  logic [2:0] tol_sel = 3'd7;
  logic       force_ref = 1'b0;
  logic       force_data = 1'b0;
  logic       lock_to_data;
  logic       freq_locked;
  int         loop_half = REF_HALF;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  cru_lock_ctrl #(.WIN_LOG2(WLOG), .PASS_NEED(2)) dut (
    .ref_clk(ref_clk), .loop_clk(loop_clk), .rst_n(rst_n),
    .sig_present(sig_present), .phase_ok(phase_ok), .tol_sel(tol_sel),
    .force_ref(force_ref), .force_data(force_data),
    .lock_to_data(lock_to_data), .freq_locked(freq_locked)
  );

  always #(REF_HALF) ref_clk = ~ref_clk;
  always #(loop_half) loop_clk = ~loop_clk;

  typedef struct packed {
    logic [2:0]  sel;
    logic [15:0] half;
    logic        sig;
    logic        ph;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd7, 16'd2500, 1'b1, 1'b1},
    '{3'd0, 16'd2500, 1'b1, 1'b1},
    '{3'd0, 16'd2498, 1'b1, 1'b1},
    '{3'd7, 16'd2498, 1'b1, 1'b1},
    '{3'd5, 16'd2498, 1'b1, 1'b1},
    '{3'd7, 16'd2450, 1'b1, 1'b1},
    '{3'd7, 16'd2500, 1'b0, 1'b1},
    '{3'd7, 16'd2500, 1'b1, 1'b0}
  };

  function automatic real ppm_of(input logic [2:0] s);
    real t [8] = '{62.5, 100.0, 125.0, 200.0, 250.0, 300.0, 500.0, 1000.0};
    return t[s];
  endfunction

  function automatic bit expect_lock(input vec_t v);
    real cnt, err, allow;
    cnt   = real'(WIN) * real'(REF_HALF) / real'(v.half);
    err   = (cnt > WIN) ? cnt - WIN : WIN - cnt;
    allow = $ceil(ppm_of(v.sel) * WIN / 1.0e6);
    return v.sig && v.ph && (err <= allow);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Waits n edges, then samples 1 ns after the last edge.
  task automatic wait_cyc(input int n);
    repeat (n) @(posedge ref_clk);
    #1000;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  initial begin
    // R1: reset state
    do_reset();
    check("R1 lock_to_data", lock_to_data, 1'b0);
    check("R1 freq_locked", freq_locked, 1'b0);

    // R3 R4 R5: table of tolerance, offset and flag patterns
    for (int i = 0; i < 8; i++) begin
      tol_sel = VECS[i].sel;
      loop_half = int'(VECS[i].half);
      sig_present = VECS[i].sig;
      phase_ok = VECS[i].ph;
      do_reset();
      wait_cyc(WIN * 33 / 10);
      check("R4 vector lock", lock_to_data, expect_lock(VECS[i]));
      check("R2 vector flag", freq_locked, expect_lock(VECS[i]));
    end

    // R6: baseline plus two passing windows
    tol_sel = 3'd7; loop_half = REF_HALF; sig_present = 1'b1; phase_ok = 1'b1;
    do_reset();
    wait_cyc(WIN * 5 / 2);
    check("R6 not yet locked", lock_to_data, 1'b0);
    wait_cyc(WIN);
    check("R6 locked", lock_to_data, 1'b1);

    // R2: phase drop while locked keeps mode
    phase_ok = 1'b0;
    wait_cyc(4);
    check("R2 phase drop keeps mode", freq_locked, 1'b1);
    phase_ok = 1'b1;

    // R7: signal loss leaves data mode after one edge
    sig_present = 1'b0;
    wait_cyc(1);
    check("R7 signal loss", lock_to_data, 1'b0);
    check("R7 flag follows", freq_locked, 1'b0);
    sig_present = 1'b1;
    wait_cyc(2);
    check("R7 re-entry", lock_to_data, 1'b1);

    // R8: failing window exits data mode
    loop_half = 2450;
    wait_cyc(WIN * 22 / 10);
    check("R8 window fail", lock_to_data, 1'b0);
    loop_half = REF_HALF;
    wait_cyc(WIN * 3 / 2);
    check("R8 qualification cleared", lock_to_data, 1'b0);

    // R11: tolerance change restarts qualification
    tol_sel = 3'd7;
    do_reset();
    wait_cyc(WIN * 3 / 2);
    tol_sel = 3'd6;
    wait_cyc(WIN * 5 / 2);
    check("R11 restart delays lock", lock_to_data, 1'b0);
    wait_cyc(WIN * 12 / 10);
    check("R11 lock after restart", lock_to_data, 1'b1);

    // R9 R10: manual overrides
    sig_present = 1'b0; phase_ok = 1'b0;
    do_reset();
    force_data = 1'b1;
    wait_cyc(2);
    check("R10 force data", lock_to_data, 1'b1);
    force_ref = 1'b1;
    wait_cyc(2);
    check("R9 force ref wins", lock_to_data, 1'b0);
    force_ref = 1'b0;
    wait_cyc(2);
    check("R10 force data again", freq_locked, 1'b1);
    force_data = 1'b0;
    wait_cyc(2);
    check("R7 auto after release", lock_to_data, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge ref_clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule